// File: doc/BRIEF.md
# Transmit Path Enable Gate

This block sits between a streaming client and a MAC transmit pipeline and decides whether the transmit path takes new frames. Software controls it through a small word-addressed register bus: a control word holds a single path-disable bit, and a read-only status word reports whether a frame is in flight and whether the transmit datapath is held in reset.

The client handshake passes through unchanged while the path is open. When disable is requested, the block lets any frame already started run to its last beat. It then closes the path at that frame boundary by holding the client's ready low and blocking the valid toward the MAC. A separate enable output lets a pause-frame generator start new frames only while the path is enabled and out of reset. Clearing the disable bit reopens the path on the next cycle.

Top module: `txgate_ctrl`

## Requirements
- R1: After reset the disable bit is 0, `pause_en` is 1 and `cl_ready` follows `mac_ready`.
- R2: The control word is at word offset 0x0020. Bit 0 written 1 disables the path and 0 enables it. Writes to bits 31:1 are ignored, and those bits read as 0.
- R3: When the disable bit is 1 and no frame is in flight, `cl_ready` and `mac_valid` are 0, starting the cycle after the write.
- R4: If disable is written while a frame is in flight, `cl_ready` keeps following `mac_ready` until the end-of-packet beat is accepted. `cl_ready` is 0 from the next cycle on.
- R5: `pause_en` is 0 from the cycle after a write of 1 to the disable bit, and stays 0 while that bit is 1 or `dp_rst` is high.
- R6: The status word is at word offset 0x0022. Bit 8 reads 1 from the cycle after an accepted start-of-packet beat, up to and including the cycle in which the end-of-packet beat is accepted. Otherwise it reads 0.
- R7: Status bit 12 reads 1 while `dp_rst` is high. While `dp_rst` is high, `cl_ready` is 0 and any frame in flight is dropped, so bit 8 reads 0 afterwards.
- R8: Writing 0 to the disable bit makes `cl_ready` follow `mac_ready` again on the cycle after the write, unless `dp_rst` is high.
- R9: Read data appears on `reg_rdata` the cycle after `reg_rd`. Unmapped offsets read 0, status bits other than 8 and 12 read 0, and writes to the status word or to unmapped offsets have no effect.
- R10: While the path is open, `mac_valid`, `mac_sop`, `mac_eop` and `mac_data` carry the client's values, and `cl_ready` equals `mac_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_rst | input | 1 | Transmit datapath held in reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, one cycle after `reg_rd` |
| cl_valid | input | 1 | Client beat valid |
| cl_sop | input | 1 | Client start-of-packet |
| cl_eop | input | 1 | Client end-of-packet |
| cl_data | input | DATA_W | Client beat data |
| cl_ready | output | 1 | Ready toward the client |
| mac_valid | output | 1 | Beat valid toward the MAC |
| mac_sop | output | 1 | Start-of-packet toward the MAC |
| mac_eop | output | 1 | End-of-packet toward the MAC |
| mac_data | output | DATA_W | Beat data toward the MAC |
| mac_ready | input | 1 | MAC ready |
| pause_en | output | 1 | Pause-frame generator enable |

## Verification
The gate is tested with three kinds of disable timing: a disable written while idle, a disable written between the first and last beat of a multi-beat frame, and a datapath reset raised in mid-frame. The idle case shows that the path closes immediately. The mid-frame case shows that the path waits for the frame boundary. The reset case shows that dropping a frame differs from completing it. Register traffic covers writes with reserved bits set, writes to the read-only and unmapped offsets, and reads of each offset. Status reads taken before, during and after a frame show that the busy bit tracks the accepted handshakes and not merely the valid signal.

// File: rtl/txgate_pkg.sv
package txgate_pkg;
  localparam int unsigned REG_WIDTH = 32;
  localparam logic [15:0] CTRL_WORD = 16'h0020;
  localparam logic [15:0] STAT_WORD = 16'h0022;
  localparam int unsigned BUSY_POS  = 8;
  localparam int unsigned RST_POS   = 12;
  localparam int unsigned DIS_POS   = 0;
endpackage

// File: rtl/txgate_regs.sv
module txgate_regs
  import txgate_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned REG_W  = REG_WIDTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              busy,
  input  logic              dp_rst,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              ctrl_dis
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_WORD);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_WORD);

  logic             ctrl_q, ctrl_d, ctrl_we;
  logic [REG_W-1:0] rdata_q, rdata_d;
  logic [REG_W-1:0] stat_word;
  logic             unused_wbits;

  assign unused_wbits = ^reg_wdata[REG_W-1:1];

  // next-state: control bit
  always_comb begin
    ctrl_we = reg_wr && (reg_addr == CTRL_A);
    ctrl_d  = reg_wdata[DIS_POS];
  end

  // status word assembly
  always_comb begin
    stat_word           = '0;
    stat_word[BUSY_POS] = busy;
    stat_word[RST_POS]  = dp_rst;
  end

  // next-state: read data
  always_comb begin
    rdata_d = '0;
    if (reg_addr == CTRL_A) begin
      rdata_d[DIS_POS] = ctrl_q;
    end else if (reg_addr == STAT_A) begin
      rdata_d = stat_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (ctrl_we) ctrl_q  <= ctrl_d;
      if (reg_rd)  rdata_q <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;
  assign ctrl_dis  = ctrl_q;
endmodule

// File: rtl/txgate_track.sv
module txgate_track (
  input  logic clk,
  input  logic rst_n,
  input  logic dp_rst,
  input  logic beat_acc,
  input  logic beat_sop,
  input  logic beat_eop,
  output logic in_frame
);
  logic fr_q, fr_d;

  always_comb begin
    fr_d = fr_q;
    if (dp_rst) begin
      fr_d = 1'b0;
    end else if (beat_acc && beat_eop) begin
      fr_d = 1'b0;
    end else if (beat_acc && beat_sop) begin
      fr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fr_q <= 1'b0;
    else        fr_q <= fr_d;
  end

  assign in_frame = fr_q;
endmodule

// File: rtl/txgate_gate.sv
module txgate_gate #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              ctrl_dis,
  input  logic              in_frame,
  input  logic              dp_rst,
  input  logic              cl_valid,
  input  logic              cl_sop,
  input  logic              cl_eop,
  input  logic [DATA_W-1:0] cl_data,
  input  logic              mac_ready,
  output logic              cl_ready,
  output logic              mac_valid,
  output logic              mac_sop,
  output logic              mac_eop,
  output logic [DATA_W-1:0] mac_data,
  output logic              pause_en,
  output logic              beat_acc
);
  logic block, path_open;

  always_comb begin
    block     = ctrl_dis && !in_frame;
    path_open = !block && !dp_rst;
    cl_ready  = mac_ready && path_open;
    mac_valid = cl_valid && path_open;
    mac_sop   = cl_sop;
    mac_eop   = cl_eop;
    mac_data  = cl_data;
    pause_en  = !ctrl_dis && !dp_rst;
    beat_acc  = cl_valid && cl_ready;
  end
endmodule

// File: rtl/txgate_ctrl.sv
module txgate_ctrl
  import txgate_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned REG_W  = REG_WIDTH,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dp_rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              cl_valid,
  input  logic              cl_sop,
  input  logic              cl_eop,
  input  logic [DATA_W-1:0] cl_data,
  output logic              cl_ready,
  output logic              mac_valid,
  output logic              mac_sop,
  output logic              mac_eop,
  output logic [DATA_W-1:0] mac_data,
  input  logic              mac_ready,
  output logic              pause_en
);
  logic ctrl_dis;
  logic in_frame;
  logic beat_acc;

  txgate_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .busy     (in_frame),
    .dp_rst   (dp_rst),
    .reg_rdata(reg_rdata),
    .ctrl_dis (ctrl_dis)
  );

  txgate_track u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .dp_rst  (dp_rst),
    .beat_acc(beat_acc),
    .beat_sop(cl_sop),
    .beat_eop(cl_eop),
    .in_frame(in_frame)
  );

  txgate_gate #(.DATA_W(DATA_W)) u_gate (
    .ctrl_dis (ctrl_dis),
    .in_frame (in_frame),
    .dp_rst   (dp_rst),
    .cl_valid (cl_valid),
    .cl_sop   (cl_sop),
    .cl_eop   (cl_eop),
    .cl_data  (cl_data),
    .mac_ready(mac_ready),
    .cl_ready (cl_ready),
    .mac_valid(mac_valid),
    .mac_sop  (mac_sop),
    .mac_eop  (mac_eop),
    .mac_data (mac_data),
    .pause_en (pause_en),
    .beat_acc (beat_acc)
  );
endmodule

// File: rtl/txgate_chk.sv
module txgate_chk
  import txgate_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned REG_W  = REG_WIDTH
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dp_rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wbit0,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              cl_valid,
  input logic              cl_sop,
  input logic              cl_eop,
  input logic              cl_ready,
  input logic              mac_valid,
  input logic              mac_ready,
  input logic              pause_en,
  input logic              ctrl_dis,
  input logic              in_frame
);
  localparam logic [REG_W-1:0] LIVE_MASK =
    (REG_W'(1) << BUSY_POS) | (REG_W'(1) << RST_POS) | (REG_W'(1) << DIS_POS);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_WORD);

  assert_rst_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dp_rst |-> !cl_ready);

  assert_idle_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_dis && !in_frame) |-> (!cl_ready && !mac_valid));

  assert_pause_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_dis |-> !pause_en);

  assert_drain_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !dp_rst && mac_ready) |-> cl_ready);

  assert_frame_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> $past(cl_valid && cl_ready && cl_sop && !cl_eop));

  assert_reopen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == CTRL_A && !wbit0) ##1 (!dp_rst && mac_ready) |-> cl_ready);

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~LIVE_MASK) == '0);
endmodule

bind txgate_ctrl txgate_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dp_rst   (dp_rst),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .reg_addr (reg_addr),
  .wbit0    (reg_wdata[0]),
  .reg_rdata(reg_rdata),
  .cl_valid (cl_valid),
  .cl_sop   (cl_sop),
  .cl_eop   (cl_eop),
  .cl_ready (cl_ready),
  .mac_valid(mac_valid),
  .mac_ready(mac_ready),
  .pause_en (pause_en),
  .ctrl_dis (ctrl_dis),
  .in_frame (in_frame)
);

// File: tb/tb_txgate_ctrl.sv
module tb_txgate_ctrl;
  localparam int AW = 16;
  localparam int RW = 32;
  localparam int DW = 64;

  logic          clk, rst_n, dp_rst;
  logic          reg_wr, reg_rd;
  logic [AW-1:0] reg_addr;
  logic [RW-1:0] reg_wdata, reg_rdata;
  logic          cl_valid, cl_sop, cl_eop, cl_ready;
  logic [DW-1:0] cl_data, mac_data;
  logic          mac_valid, mac_sop, mac_eop, mac_ready, pause_en;

  int checks = 0;
  int errors = 0;

  txgate_ctrl #(.ADDR_W(AW), .REG_W(RW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .dp_rst(dp_rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cl_valid(cl_valid), .cl_sop(cl_sop), .cl_eop(cl_eop), .cl_data(cl_data),
    .cl_ready(cl_ready), .mac_valid(mac_valid), .mac_sop(mac_sop),
    .mac_eop(mac_eop), .mac_data(mac_data), .mac_ready(mac_ready),
    .pause_en(pause_en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [RW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    #1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [RW-1:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    #1;
    d = reg_rdata;
  endtask

  // drive a beat and leave it for the next edge to take
  task automatic beat(input logic s, input logic e, input logic [DW-1:0] d);
    @(negedge clk);
    cl_valid = 1'b1; cl_sop = s; cl_eop = e; cl_data = d;
    #1;
  endtask

  task automatic idle_bus();
    @(negedge clk);
    cl_valid = 1'b0; cl_sop = 1'b0; cl_eop = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    logic [RW-1:0] v;
    #1;
    check("R1 ready", cl_ready, 1);
    check("R1 pause_en", pause_en, 1);
    rd(16'h0020, v);
    check("R1 ctrl reset", v, 0);
  endtask

  task automatic t_pass();
    beat(1'b1, 1'b0, 64'hA5A5_0001_DEAD_BEEF);
    check("R10 mac_valid", mac_valid, 1);
    check("R10 mac_data", mac_data, 64'hA5A5_0001_DEAD_BEEF);
    check("R10 mac_sop", mac_sop, 1);
    mac_ready = 1'b0; #1;
    check("R10 ready follows mac", cl_ready, 0);
    mac_ready = 1'b1; #1;
    beat(1'b0, 1'b1, 64'h2);
    check("R10 mac_eop", mac_eop, 1);
    idle_bus();
  endtask

  task automatic t_regs();
    logic [RW-1:0] v;
    wr(16'h0020, 32'hFFFF_FFFF);
    rd(16'h0020, v);
    check("R2 reserved ignored", v, 32'h1);
    wr(16'h0020, 32'hFFFF_FFFE);
    rd(16'h0020, v);
    check("R2 enable readback", v, 32'h0);
    wr(16'h0022, 32'hFFFF_FFFF);
    wr(16'h0030, 32'h1);
    check("R9 writes elsewhere no effect", cl_ready, 1);
    rd(16'h0020, v);
    check("R9 ctrl untouched", v, 0);
    rd(16'h0021, v);
    check("R9 unmapped reads 0", v, 0);
    rd(16'h0022, v);
    check("R9 idle status", v, 0);
  endtask

  task automatic t_idle_disable();
    cl_valid = 1'b1; cl_sop = 1'b1; cl_eop = 1'b1;
    wr(16'h0020, 32'h1);
    check("R3 ready low", cl_ready, 0);
    check("R3 mac_valid low", mac_valid, 0);
    check("R5 pause off", pause_en, 0);
    idle_bus();
    wr(16'h0020, 32'h0);
    check("R8 reopened", cl_ready, 1);
    check("R5 pause back", pause_en, 1);
  endtask

  task automatic t_drain();
    logic [RW-1:0] v;
    beat(1'b1, 1'b0, 64'h10);
    idle_bus();
    rd(16'h0022, v);
    check("R6 busy mid frame", v, 32'h100);
    wr(16'h0020, 32'h1);
    check("R4 still open in frame", cl_ready, 1);
    check("R5 pause off while draining", pause_en, 0);
    beat(1'b0, 1'b0, 64'h11);
    check("R4 middle beat accepted", cl_ready, 1);
    beat(1'b0, 1'b1, 64'h12);
    check("R4 last beat accepted", cl_ready, 1);
    idle_bus();
    check("R4 closed after eop", cl_ready, 0);
    rd(16'h0022, v);
    check("R6 busy cleared", v, 0);
    wr(16'h0020, 32'h0);
    check("R8 reopen after drain", cl_ready, 1);
  endtask

  task automatic t_dp_reset();
    logic [RW-1:0] v;
    beat(1'b1, 1'b0, 64'h20);
    idle_bus();
    wr(16'h0020, 32'h1);
    dp_rst = 1'b1; #1;
    check("R7 ready low in reset", cl_ready, 0);
    rd(16'h0022, v);
    check("R7 reset bit", v, 32'h1000);
    wr(16'h0020, 32'h0);
    check("R8 no reopen under reset", cl_ready, 0);
    check("R7 pause off in reset", pause_en, 0);
    wr(16'h0020, 32'h1);
    @(negedge clk); dp_rst = 1'b0; #1;
    check("R7 frame dropped, closed", cl_ready, 0);
    rd(16'h0022, v);
    check("R7 busy cleared by reset", v, 0);
    wr(16'h0020, 32'h0);
    check("R8 reopen after reset", cl_ready, 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dp_rst = 1'b0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    cl_valid = 1'b0; cl_sop = 1'b0; cl_eop = 1'b0; cl_data = '0;
    mac_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pass();
    t_regs();
    t_idle_disable();
    t_drain();
    t_dp_reset();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule